// File: doc/BRIEF.md
# Card Window Address Decoder

The block holds the address window bank of a two-slot PC card controller. Each window is a pair of 32-bit registers, a base and an option word. Software reaches them through a small register port. On every host access the block compares the address against every valid window, picks the matching window with the lowest number, and reports the target slot and the card space type. It also reports the port width, the write-protect state and the three bus-clock timing counts stored for that window. A card bus sequencer placed after this block consumes the result.

The window size is not a power-of-two exponent. It is a 5-bit code with a scrambled ordering, and some codes are unused. There is no offset register, so a window passes the host address straight through to the card. The result is registered and appears one cycle after the access is presented.

Top module: `cwin_decoder`

## Requirements
- R1: There are NUM_WIN (default 8) windows. Register index 2w holds the base of window w and index 2w+1 holds its option word. `reg_rdata` returns the addressed 32-bit register combinationally. A write with `reg_wr` high is visible from the next cycle. After reset every register reads zero.
- R2: Window w matches an access when option bit 0 (valid) is 1, its size code is supported, and `acc_addr` equals the base in every bit at or above log2(size). The size code is option bits 31:27.
- R3: Size codes decode to bytes as follows. Codes 0..3 give 1, 2, 8, 4. Codes 4..7 give 128, 64, 16, 32. Codes 8..11 give 32K, 16K, 4K, 8K. Codes 12..15 give 256, 512, 2K, 1K. Codes 20, 21 and 23 give 16M, 32M and 64M. Codes 24..31 give 64K, 128K, 512K, 256K, 8M, 4M, 1M, 2M.
- R4: Size codes 16, 17, 18, 19 and 22 never produce a match, whatever the base and the valid bit hold.
- R5: When several windows match, `res_win` and every reported field come from the lowest-numbered matching window.
- R6: On a hit the block reports the following fields of the selected option word: `res_slot` from bit 2, `res_wp` from bit 1, `res_wide` from bit 6, `res_hold` from bits 18:16, `res_setup` from bits 15:12 and `res_strobe` from bits 11:7.
- R7: `res_space` is 0 (common memory) when option bit 4 is 0. It is 1 (attribute memory) when bits 4:3 are 2'b10, and 2 (I/O) when bits 4:3 are 2'b11.
- R8: When an access matches no window, `res_nohit` is 1, `res_hit` is 0, and the window, field, start and error outputs are all 0.
- R9: A write access (`acc_write`=1) that hits a window with write-protect set gives a one-cycle `res_wp_err` and leaves `res_start` at 0. Any other hit gives `res_start`=1 and `res_wp_err`=0.
- R10: Writing zero to an option word disables that window for every later access. An access in the same cycle as the write still decodes against the old contents.
- R11: The results for an access presented in cycle N appear in cycle N+1 with `res_valid`=1. In a cycle after no access, `res_valid` and all other result outputs are 0.
- R12: While `rst_n` is low at a clock edge, all result outputs and all window registers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index: 2w base, 2w+1 option |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| acc_valid | input | 1 | Host access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Host access address |
| res_valid | output | 1 | Result for last cycle's access |
| res_hit | output | 1 | A window matched |
| res_nohit | output | 1 | No window matched |
| res_win | output | 3 | Selected window number |
| res_slot | output | 1 | Target slot |
| res_space | output | 2 | 0 common, 1 attribute, 2 I/O |
| res_wide | output | 1 | 16-bit port width |
| res_wp | output | 1 | Window write-protected |
| res_hold | output | 3 | Hold time in bus clocks |
| res_setup | output | 4 | Setup time in bus clocks |
| res_strobe | output | 5 | Strobe length in bus clocks |
| res_start | output | 1 | Card cycle may start |
| res_wp_err | output | 1 | Write to protected window |

## Verification
The bench builds the block with its defaults: eight windows and a 32-bit address. This allows the 64 MB code to be exercised alongside single-byte windows, windows with both slot values, and nested windows where priority decides the result. One window is swept through all 32 size codes, probing at its base and just past each size boundary, so the scrambled ordering and the unsupported codes are all covered. Pseudo-random addresses over the programmed regions then stress priority, and a zero option write made together with an access checks the old-versus-new ordering.

// File: rtl/cwin_pkg.sv
// Shared definitions for the card window decoder.
// Assumes a 32-bit register word; field positions are fixed by the option layout.
package cwin_pkg;
    localparam int REG_W     = 32;
    localparam int SZ_HI     = 31;
    localparam int SZ_LO     = 27;
    localparam int HOLD_HI   = 18;
    localparam int HOLD_LO   = 16;
    localparam int SETUP_HI  = 15;
    localparam int SETUP_LO  = 12;
    localparam int STRB_HI   = 11;
    localparam int STRB_LO   = 7;
    localparam int WIDE_BIT  = 6;
    localparam int SPC_HI    = 4;
    localparam int SPC_LO    = 3;
    localparam int SLOT_BIT  = 2;
    localparam int WP_BIT    = 1;
    localparam int VLD_BIT   = 0;

    typedef enum logic [1:0] {
        SPACE_COMMON = 2'd0,
        SPACE_ATTR   = 2'd1,
        SPACE_IO     = 2'd2
    } space_e;

    typedef struct packed {
        logic       ok;
        logic [4:0] lg;
    } size_t;

    // Size code to log2 of the byte size; ok=0 for unused codes.
    function automatic size_t size_decode(input logic [4:0] code);
        size_t r;
        r.ok = 1'b1;
        case (code)
            5'd0:  r.lg = 5'd0;
            5'd1:  r.lg = 5'd1;
            5'd2:  r.lg = 5'd3;
            5'd3:  r.lg = 5'd2;
            5'd4:  r.lg = 5'd7;
            5'd5:  r.lg = 5'd6;
            5'd6:  r.lg = 5'd4;
            5'd7:  r.lg = 5'd5;
            5'd8:  r.lg = 5'd15;
            5'd9:  r.lg = 5'd14;
            5'd10: r.lg = 5'd12;
            5'd11: r.lg = 5'd13;
            5'd12: r.lg = 5'd8;
            5'd13: r.lg = 5'd9;
            5'd14: r.lg = 5'd11;
            5'd15: r.lg = 5'd10;
            5'd20: r.lg = 5'd24;
            5'd21: r.lg = 5'd25;
            5'd23: r.lg = 5'd26;
            5'd24: r.lg = 5'd16;
            5'd25: r.lg = 5'd17;
            5'd26: r.lg = 5'd19;
            5'd27: r.lg = 5'd18;
            5'd28: r.lg = 5'd23;
            5'd29: r.lg = 5'd22;
            5'd30: r.lg = 5'd20;
            5'd31: r.lg = 5'd21;
            default: begin
                r.ok = 1'b0;
                r.lg = 5'd0;
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cwin_regbank.sv
// Window register bank: NUM_WIN base/option pairs at consecutive indices.
// Assumes software writes whole words; an index past the bank is ignored.
module cwin_regbank
    import cwin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(2 * NUM_WIN),
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [IDX_W-1:0]               reg_idx,
    input  logic [REG_W-1:0]               reg_wdata,
    output logic [REG_W-1:0]               reg_rdata,
    output logic [NUM_WIN-1:0][REG_W-1:0]  bases,
    output logic [NUM_WIN-1:0][REG_W-1:0]  opts
);
    logic [IDX_W-2:0] win_sel;
    logic             is_opt;
    logic             in_range;

    assign win_sel  = reg_idx[IDX_W-1:1];
    assign is_opt   = reg_idx[0];
    assign in_range = (int'(win_sel) < NUM_WIN);

    // Register storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bases <= '0;
            opts  <= '0;
        end else if (reg_wr && in_range) begin
            if (is_opt) opts[WIN_W'(win_sel)]  <= reg_wdata;
            else        bases[WIN_W'(win_sel)] <= reg_wdata;
        end
    end

    // Combinational read-back of the addressed word.
    always_comb begin
        reg_rdata = '0;
        if (in_range)
            reg_rdata = is_opt ? opts[WIN_W'(win_sel)] : bases[WIN_W'(win_sel)];
    end
endmodule

// File: rtl/cwin_window_cmp.sv
// One window comparator: decodes the size code and tests the address
// against the base above the size boundary. Assumes ADDR_W of 27 to 32.
module cwin_window_cmp
    import cwin_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [REG_W-1:0]  base,
    input  logic [REG_W-1:0]  opt,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);
    size_t             sz;
    logic [ADDR_W-1:0] keep;

    // Decode size and compare the kept address bits.
    always_comb begin
        sz    = size_decode(opt[SZ_HI:SZ_LO]);
        keep  = {ADDR_W{1'b1}} << sz.lg;
        match = opt[VLD_BIT] && sz.ok &&
                (((addr ^ base[ADDR_W-1:0]) & keep) == '0);
    end
endmodule

// File: rtl/cwin_select.sv
// Priority selection and result register: the lowest matching window wins;
// its option fields are registered together with hit, start and error flags.
module cwin_select
    import cwin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WIN-1:0]            match,
    input  logic [NUM_WIN-1:0][REG_W-1:0] opts,
    input  logic                          acc_valid,
    input  logic                          acc_write,
    output logic                          res_valid,
    output logic                          res_hit,
    output logic                          res_nohit,
    output logic [WIN_W-1:0]              res_win,
    output logic                          res_slot,
    output logic [1:0]                    res_space,
    output logic                          res_wide,
    output logic                          res_wp,
    output logic [2:0]                    res_hold,
    output logic [3:0]                    res_setup,
    output logic [4:0]                    res_strobe,
    output logic                          res_start,
    output logic                          res_wp_err
);
    logic             any;
    logic [WIN_W-1:0] pick;
    logic [REG_W-1:0] sel;
    space_e           spc;
    logic             unused_bits;

    // Lowest-index matching window, found by a descending scan.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (match[w]) begin
                any  = 1'b1;
                pick = WIN_W'(w);
            end
        end
        sel = any ? opts[pick] : '0;
    end

    // Space type from the two type bits.
    always_comb begin
        if (!sel[SPC_HI])     spc = SPACE_COMMON;
        else if (!sel[SPC_LO]) spc = SPACE_ATTR;
        else                   spc = SPACE_IO;
    end

    assign unused_bits = ^{sel[SZ_HI:HOLD_HI+1], sel[5], sel[VLD_BIT]};

    // Result register, cleared when no access was presented.
    always_ff @(posedge clk) begin
        if (!rst_n || !acc_valid) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_nohit  <= 1'b0;
            res_win    <= '0;
            res_slot   <= 1'b0;
            res_space  <= 2'd0;
            res_wide   <= 1'b0;
            res_wp     <= 1'b0;
            res_hold   <= '0;
            res_setup  <= '0;
            res_strobe <= '0;
            res_start  <= 1'b0;
            res_wp_err <= 1'b0;
        end else begin
            res_valid  <= 1'b1;
            res_hit    <= any;
            res_nohit  <= !any;
            res_win    <= pick;
            res_slot   <= sel[SLOT_BIT];
            res_space  <= any ? spc : SPACE_COMMON;
            res_wide   <= sel[WIDE_BIT];
            res_wp     <= sel[WP_BIT];
            res_hold   <= sel[HOLD_HI:HOLD_LO];
            res_setup  <= sel[SETUP_HI:SETUP_LO];
            res_strobe <= sel[STRB_HI:STRB_LO];
            res_start  <= any && !(acc_write && sel[WP_BIT]);
            res_wp_err <= any && acc_write && sel[WP_BIT];
        end
    end
endmodule

// File: rtl/cwin_decoder.sv
// Card window address decoder top: register bank, one comparator per
// window and the priority/result stage. Result latency is one cycle.
module cwin_decoder
    import cwin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(2 * NUM_WIN),
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_nohit,
    output logic [WIN_W-1:0]  res_win,
    output logic              res_slot,
    output logic [1:0]        res_space,
    output logic              res_wide,
    output logic              res_wp,
    output logic [2:0]        res_hold,
    output logic [3:0]        res_setup,
    output logic [4:0]        res_strobe,
    output logic              res_start,
    output logic              res_wp_err
);
    logic [NUM_WIN-1:0][REG_W-1:0] bases;
    logic [NUM_WIN-1:0][REG_W-1:0] opts;
    logic [NUM_WIN-1:0]            match;

    cwin_regbank #(.NUM_WIN(NUM_WIN)) u_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bases(bases), .opts(opts)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        cwin_window_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .base(bases[w]), .opt(opts[w]), .addr(acc_addr), .match(match[w])
        );
    end

    cwin_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .clk(clk), .rst_n(rst_n), .match(match), .opts(opts),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .res_valid(res_valid), .res_hit(res_hit), .res_nohit(res_nohit),
        .res_win(res_win), .res_slot(res_slot), .res_space(res_space),
        .res_wide(res_wide), .res_wp(res_wp), .res_hold(res_hold),
        .res_setup(res_setup), .res_strobe(res_strobe),
        .res_start(res_start), .res_wp_err(res_wp_err)
    );
endmodule

// File: rtl/cwin_checker.sv
// Temporal checks on the decoder ports; attached to every decoder by bind.
module cwin_checker #(
    parameter int WIN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_nohit,
    input logic [WIN_W-1:0] res_win,
    input logic [1:0]       res_space,
    input logic             res_wp,
    input logic             res_slot,
    input logic             res_start,
    input logic             res_wp_err
);
    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_nohit));

    assert_nohit_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_nohit |-> (res_win == '0 && res_space == 2'd0 && !res_wp &&
                       !res_slot && !res_start && !res_wp_err));

    assert_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!res_valid && !res_hit && !res_nohit && !res_start));

    assert_wperr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_wp_err |-> (res_hit && res_wp && !res_start));

    assert_wpwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> (res_wp_err == (res_hit && res_wp)));

    assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_start |-> (res_hit && !res_wp_err));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wp_err && !acc_valid) |=> !res_wp_err);

    assert_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_space != 2'd3);
endmodule

bind cwin_decoder cwin_checker #(.WIN_W(WIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .res_valid(res_valid), .res_hit(res_hit), .res_nohit(res_nohit),
    .res_win(res_win), .res_space(res_space), .res_wp(res_wp),
    .res_slot(res_slot), .res_start(res_start), .res_wp_err(res_wp_err)
);

// File: tb/sim_cwin_decoder.sv
// Bench: behavioural window model, compared against the decoder every cycle.
module sim_cwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        res_valid, res_hit, res_nohit, res_slot, res_wide, res_wp;
    logic        res_start, res_wp_err;
    logic [2:0]  res_win, res_hold;
    logic [1:0]  res_space;
    logic [3:0]  res_setup;
    logic [4:0]  res_strobe;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    logic [31:0] m_base [8];
    logic [31:0] m_opt  [8];
    logic [24:0] exp_vec;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    cwin_decoder u0 (.*);

    // Byte size for a code; 0 marks an unused code.
    function automatic longint code_bytes(input int c);
        case (c)
            0: return 1;        1: return 2;        2: return 8;        3: return 4;
            4: return 128;      5: return 64;       6: return 16;       7: return 32;
            8: return 32768;    9: return 16384;    10: return 4096;    11: return 8192;
            12: return 256;     13: return 512;     14: return 2048;    15: return 1024;
            20: return 64'd16777216; 21: return 64'd33554432; 23: return 64'd67108864;
            24: return 65536;   25: return 131072;  26: return 524288;  27: return 262144;
            28: return 64'd8388608;  29: return 64'd4194304;  30: return 64'd1048576;
            31: return 64'd2097152;
            default: return 0;
        endcase
    endfunction

    // Expected result vector for the inputs now on the pins.
    task automatic model_result();
        int hitw = -1;
        logic [31:0] o;
        logic [1:0] sp;
        exp_vec = '0;
        if (rst_n && acc_valid) begin
            for (int w = 0; w < 8; w++) begin
                longint sz = code_bytes(int'(m_opt[w][31:27]));
                logic [31:0] msk = ~(32'(sz) - 32'd1);
                if (hitw < 0 && m_opt[w][0] && sz != 0 &&
                    ((acc_addr & msk) == (m_base[w] & msk)))
                    hitw = w;
            end
            if (hitw < 0) begin
                exp_vec = {1'b1, 1'b0, 1'b1, 22'd0};
            end else begin
                o  = m_opt[hitw];
                sp = (o[4] == 1'b0) ? 2'd0 : (o[3] ? 2'd2 : 2'd1);
                exp_vec = {1'b1, 1'b1, 1'b0, 3'(hitw), o[2], sp, o[6], o[1],
                           o[18:16], o[15:12], o[11:7],
                           !(acc_write && o[1]), (acc_write && o[1])};
            end
        end
    endtask

    // One clock: predict, update model, step, compare at the falling edge.
    task automatic tick(input string tag);
        logic [24:0] got;
        logic [31:0] exp_rd;
        model_result();
        if (!rst_n) begin
            for (int w = 0; w < 8; w++) begin
                m_base[w] = '0;
                m_opt[w]  = '0;
            end
        end else if (reg_wr) begin
            if (reg_idx[0]) m_opt[reg_idx[3:1]]  = reg_wdata;
            else            m_base[reg_idx[3:1]] = reg_wdata;
        end
        @(posedge clk);
        @(negedge clk);
        got = {res_valid, res_hit, res_nohit, res_win, res_slot, res_space,
               res_wide, res_wp, res_hold, res_setup, res_strobe,
               res_start, res_wp_err};
        exp_rd = reg_idx[0] ? m_opt[reg_idx[3:1]] : m_base[reg_idx[3:1]];
        compared++;
        if (got !== exp_vec) begin
            mismatched++;
            $display("FAIL %s result actual=%h expected=%h", tag, got, exp_vec);
        end
        compared++;
        if (reg_rdata !== exp_rd) begin
            mismatched++;
            $display("FAIL R1 %s readback idx=%0d actual=%h expected=%h",
                     tag, reg_idx, reg_rdata, exp_rd);
        end
    endtask

    task automatic wr_reg(input int idx, input logic [31:0] d);
        reg_wr = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
        tick("R1");
        reg_wr = 1'b0;
        tick("R1");
    endtask

    task automatic access(input logic [31:0] a, input logic w, input string tag);
        acc_valid = 1'b1; acc_write = w; acc_addr = a;
        tick(tag);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 8; w++) begin
            m_base[w] = 'x;
            m_opt[w]  = 'x;
        end
        @(negedge clk);
        // R12: reset clears registers and outputs
        acc_valid = 1'b1; acc_addr = 32'h0;
        tick("R12");
        tick("R12");
        acc_valid = 1'b0;
        rst_n = 1'b1;
        tick("R12");
        for (int i = 0; i < 16; i++) begin
            reg_idx = 4'(i);
            tick("R1");
        end
        access(32'h0000_0000, 1'b0, "R8");

        // Program the bank
        wr_reg(0,  32'hE000_0000); wr_reg(1,  32'hB802_3481);
        wr_reg(2,  32'hE400_0000); wr_reg(3,  32'hB807_FFD5);
        wr_reg(4,  32'h0001_1000); wr_reg(5,  32'h5000_001B);
        wr_reg(6,  32'h0001_0000); wr_reg(7,  32'hC000_0005);
        wr_reg(8,  32'h8000_0000); wr_reg(9,  32'h8800_0001);
        wr_reg(10, 32'h0000_0100); wr_reg(11, 32'h1800_0001);
        wr_reg(12, 32'h0020_0000); wr_reg(13, 32'hE000_0000);
        wr_reg(14, 32'h0000_0300); wr_reg(15, 32'h0000_0001);

        access(32'hE000_0010, 1'b0, "R6");
        access(32'hE000_0010, 1'b1, "R9");
        access(32'hE3FF_FFFF, 1'b0, "R2");
        access(32'hE7FF_FFFF, 1'b0, "R7");
        access(32'hE800_0000, 1'b0, "R8");
        access(32'h0001_1234, 1'b0, "R5");
        access(32'h0001_1234, 1'b1, "R9");
        access(32'h0001_5000, 1'b1, "R7");
        access(32'h0002_0000, 1'b0, "R8");
        access(32'h8000_0000, 1'b0, "R4");
        access(32'h0000_0103, 1'b0, "R3");
        access(32'h0000_0104, 1'b0, "R3");
        access(32'h0020_0000, 1'b0, "R2");
        access(32'h0000_0300, 1'b0, "R3");
        access(32'h0000_0301, 1'b0, "R3");
        // back-to-back accesses, no gap
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'h0001_1FFF;
        tick("R11");
        acc_write = 1'b0; acc_addr = 32'hE400_0004;
        tick("R11");
        acc_valid = 1'b0;
        tick("R11");

        // Sweep every size code on window 6
        wr_reg(12, 32'h4000_0000);
        for (int c = 0; c < 32; c++) begin
            longint sz = code_bytes(c);
            wr_reg(13, {5'(c), 27'h0000_0081});
            access(32'h4000_0000, 1'b0, (sz == 0) ? "R4" : "R3");
            access(32'h4000_0000 + ((sz == 0) ? 32'h1 : 32'(sz) - 32'd1), 1'b0, "R3");
            access(32'h4000_0000 + ((sz == 0) ? 32'h100 : 32'(sz)), 1'b1, "R2");
        end
        // unused code with all other bits set must not match
        wr_reg(13, 32'hB07F_FFFF);
        access(32'h4000_0000, 1'b0, "R4");
        wr_reg(13, 32'h9000_0001);
        access(32'h4000_0010, 1'b0, "R4");

        // Pseudo-random accesses over the programmed regions
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[3:2])
                2'd0: acc_addr = {6'b111000, lfsr[31:6]};
                2'd1: acc_addr = {15'd0, lfsr[31:15]};
                2'd2: acc_addr = {22'd0, lfsr[31:22]};
                default: acc_addr = lfsr;
            endcase
            acc_valid = lfsr[4] | lfsr[5];
            acc_write = lfsr[7];
            tick("R5");
        end
        acc_valid = 1'b0; acc_write = 1'b0;
        tick("R11");

        // R10: zero option together with an access, then again
        reg_wr = 1'b1; reg_idx = 4'd1; reg_wdata = 32'h0;
        acc_valid = 1'b1; acc_addr = 32'hE000_0020;
        tick("R10");
        reg_wr = 1'b0;
        tick("R10");
        acc_valid = 1'b0;
        tick("R10");
        access(32'hE000_0020, 1'b1, "R10");

        // R12: reset mid-run clears everything
        rst_n = 1'b0;
        tick("R12");
        rst_n = 1'b1;
        access(32'h0000_0300, 1'b0, "R12");
        reg_idx = 4'd15;
        tick("R12");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule